// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Controller

This block lets any core of a small multicore cluster interrupt any other core and hand it a 16-bit payload. Every core owns a pair of 32-bit words in a compact register window: a control word that the core writes to send or acknowledge, and a status word that records the last message delivered to it. Each core also has one level-sensitive interrupt line, which stays high while a message is waiting for it.

A core sends by writing its own control word with the send bit set, the destination index in a 14-bit field and the payload in the low half. The destination's status word is rebuilt from a pending flag, the sender's index and the payload, and the destination's line rises. The receiver reads its status word to learn who sent what, then writes its own control word with the acknowledge bit set to drop the pending flag and its line. Each destination holds at most one message; a new send overwrites the old one.

The register bus is plain and has no handshake. It takes one write per cycle, and write effects are visible from the next clock edge on. Reads are combinational from stored state, so there is no back-pressure on either path.

Top module: `ipi_ctrl`

## Requirements
- R1: Address bit 2 selects the control word (0) or the status word (1), and address bits ADDR_W-1:3 give the core index, so core c's control word is at byte address 8c and its status word at 8c+4. When the index is at or above NUM_CORES, a write changes nothing and a read returns 0.
- R2: A write to a core's control word stores the whole 32-bit value in that word, whatever its bits are, and the word reads back unchanged until the same core writes again.
- R3: When a control write has bit 30 (send) set and its bits 29:16 name a core below NUM_CORES, then from the next clock edge that core's status word reads 0x4000_0000 OR (writer index << 16) OR (written bits 15:0), and its interrupt line is high.
- R4: When a control write has bit 31 (acknowledge) set, then from the next clock edge the writer's own status bit 30 is 0 and its interrupt line is low. All other status bits keep their values.
- R5: When one write sets both send and acknowledge, the send is applied first and the acknowledge second. A core that sends to itself this way ends with its line low and its status word holding its own index and payload with bit 30 clear.
- R6: A send whose destination field (bits 29:16) is at or above NUM_CORES changes no status word and no interrupt line.
- R7: Writes to a status word are ignored: no status word, control word or interrupt line changes.
- R8: After reset every control word and status word reads 0 and every interrupt line is low.
- R9: Each core's interrupt line equals bit 30 of its status word at every clock edge after reset. A send to a core that already has a message pending replaces that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_CORES | Level interrupt line, one per core |

## Verification
The hardest situation to reach is a single write that acts on two slots at once: a send plus acknowledge from a core that has its own message pending, aimed either at another core or at itself. Only the ordering rule decides the outcome. The bench first parks a message at the writer, then issues the combined write to each kind of target. After every write it compares all words and lines with a bench model built from the requirements. A full sweep over every sender and receiver pair, including self-sends, sets up each pending state before its acknowledge. Out-of-range destinations, out-of-range addresses and status writes are checked while messages are pending, so that any stray change would show up.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_F_W  = 14;
  localparam int DATA_F_W = 16;
  localparam int ACK_BIT  = 31;
  localparam int SEND_BIT = 30;
  localparam int DST_LSB  = 16;

  function automatic logic [WORD_W-1:0] build_status(
      input logic [IDX_F_W-1:0]  src,
      input logic [DATA_F_W-1:0] payload);
    return {1'b0, 1'b1, src, payload};
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [NUM_CORES-1:0] ctrl_we,
  output logic [NUM_CORES-1:0] send_hit,
  output logic [NUM_CORES-1:0] ack_en,
  output logic [IDX_F_W-1:0]   src_idx,
  output logic                 rd_ok,
  output logic                 rd_status
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0]  slot;
  logic [IDX_F_W-1:0] dst;
  logic               slot_ok;
  logic               dst_ok;
  logic               ctrl_wr;
  logic               unused_low;

  assign slot       = bus_addr[ADDR_W-1:3];
  assign dst        = bus_wdata[DST_LSB +: IDX_F_W];
  assign slot_ok    = 32'(slot) < NUM_CORES;
  assign dst_ok     = 32'(dst) < NUM_CORES;
  assign ctrl_wr    = bus_we && !bus_addr[2] && slot_ok;
  assign src_idx    = IDX_F_W'(slot);
  assign rd_ok      = slot_ok;
  assign rd_status  = bus_addr[2];
  assign unused_low = ^bus_addr[1:0];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_sel
    assign ctrl_we[g]  = ctrl_wr && (32'(slot) == g);
    assign send_hit[g] = ctrl_wr && bus_wdata[SEND_BIT] && dst_ok && (32'(dst) == g);
    assign ack_en[g]   = ctrl_we[g] && bus_wdata[ACK_BIT];
  end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic                send_hit,
  input  logic                ack_en,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [IDX_F_W-1:0]  src_idx,
  output logic [WORD_W-1:0]   ctrl_q,
  output logic [WORD_W-1:0]   status_q,
  output logic                irq_q
);
  logic [WORD_W-1:0] status_d;
  logic              irq_d;

  // send first, then acknowledge, so a self-send with ack ends cleared
  always_comb begin
    status_d = status_q;
    irq_d    = irq_q;
    if (send_hit) begin
      status_d = build_status(src_idx, wdata[DATA_F_W-1:0]);
      irq_d    = 1'b1;
    end
    if (ack_en) begin
      status_d[SEND_BIT] = 1'b0;
      irq_d              = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_q == $past(wdata));
  assert_send_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (send_hit && !ack_en) |=> irq_q && status_q[SEND_BIT]);
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |=> !irq_q && !status_q[SEND_BIT]);
  assert_ack_keeps_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !send_hit) |=> status_q[SEND_BIT-1:0] == $past(status_q[SEND_BIT-1:0]));
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_hit && !ack_en) |=> $stable(status_q) && $stable(irq_q));
  assert_line_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == status_q[SEND_BIT]);
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 1,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [NUM_CORES-1:0] ctrl_we;
  logic [NUM_CORES-1:0] send_hit;
  logic [NUM_CORES-1:0] ack_en;
  logic [IDX_F_W-1:0]   src_idx;
  logic                 rd_ok;
  logic                 rd_status;
  logic [WORD_W-1:0]    ctrl_q   [NUM_CORES];
  logic [WORD_W-1:0]    status_q [NUM_CORES];

  ipi_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .ctrl_we  (ctrl_we),
    .send_hit (send_hit),
    .ack_en   (ack_en),
    .src_idx  (src_idx),
    .rd_ok    (rd_ok),
    .rd_status(rd_status)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    ipi_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (ctrl_we[g]),
      .send_hit(send_hit[g]),
      .ack_en  (ack_en[g]),
      .wdata   (bus_wdata),
      .src_idx (src_idx),
      .ctrl_q  (ctrl_q[g]),
      .status_q(status_q[g]),
      .irq_q   (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (rd_ok && (32'(bus_addr[ADDR_W-1:3]) == i))
        bus_rdata = rd_status ? status_q[i] : ctrl_q[i];
    end
  end

  logic far_send;
  assign far_send = bus_we && !bus_addr[2] && bus_wdata[SEND_BIT] && !bus_wdata[ACK_BIT]
                    && (32'(bus_wdata[DST_LSB +: IDX_F_W]) >= NUM_CORES);

  logic far_slot;
  assign far_slot = bus_we && (32'(bus_addr[ADDR_W-1:3]) >= NUM_CORES);

  assert_far_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    far_send |=> $stable(irq_o));
  assert_far_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    far_slot |=> $stable(irq_o));
  assert_status_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[2]) |=> $stable(irq_o));
  assert_single_writer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_we) && $onehot0(send_hit));
  assert_slot_width_ok: assert property (@(posedge clk) disable iff (!rst_n)
    SLOT_W > 0);
endmodule

// File: tb/tb_ipi_ctrl.sv
module tb_ipi_ctrl;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam logic [31:0] SEND = 32'h4000_0000;
  localparam logic [31:0] ACK  = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl [N];
  logic [31:0] m_stat [N];

  always #2 clk = ~clk;

  ipi_ctrl #(.NUM_CORES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] msg(input int src, input logic [15:0] p);
    return SEND[31:0] | (32'(src) << 16) | 32'(p);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_ctrl[i] = '0;
      m_stat[i] = '0;
    end
  endtask

  // model written from R1..R7: send first, then acknowledge
  task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
    int s;
    int t;
    s = int'(a >> 3);
    t = int'(d[29:16]);
    if (s < N && !a[2]) begin
      m_ctrl[s] = d;
      if (d[30] && t < N) m_stat[t] = msg(s, d[15:0]);
      if (d[31]) m_stat[s][30] = 1'b0;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) begin
      rd(AW'(i * 8), v);
      check({tag, " R2 ctrl"}, v, m_ctrl[i]);
      rd(AW'(i * 8 + 4), v);
      check({tag, " R3 status"}, v, m_stat[i]);
      e[i] = m_stat[i][30];
    end
    check({tag, " R9 lines"}, 32'(irq_o), 32'(e));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R8 reset");

    // R3/R4: every sender and receiver, including self
    for (int s = 0; s < N; s++) begin
      for (int t = 0; t < N; t++) begin
        logic [15:0] p;
        p = 16'(16'hA500 + s * 37 + t * 11);
        wr(AW'(s * 8), SEND | (32'(t) << 16) | 32'(p));
        check("R3 line to dest", 32'(irq_o), 32'(1 << t));
        check_all("R3 sweep send");
        wr(AW'(t * 8), ACK);
        check("R4 line after ack", 32'(irq_o), 32'h0);
        check_all("R4 sweep ack");
      end
    end

    // R5: writer has a pending message, sends to another with ack
    wr(AW'(1 * 8), SEND | (32'(0) << 16) | 32'h1111);
    wr(AW'(0 * 8), ACK | SEND | (32'(2) << 16) | 32'h2222);
    check("R5 both effects", 32'(irq_o), 32'h4);
    rd(AW'(0 * 8 + 4), v);
    check("R5 writer status", v, 32'h0001_1111);
    check_all("R5 combined");

    // R5: self-send with ack ends cleared
    wr(AW'(3 * 8), ACK | SEND | (32'(3) << 16) | 32'hBEEF);
    rd(AW'(3 * 8 + 4), v);
    check("R5 self-send status", v, 32'h0003_BEEF);
    check("R5 self-send line", 32'(irq_o), 32'h4);
    check_all("R5 self");

    // R6: destinations at or above core count
    wr(AW'(1 * 8), SEND | (32'(4) << 16) | 32'h5555);
    check_all("R6 dest 4");
    wr(AW'(2 * 8), SEND | (32'h3FFF << 16) | 32'h6666);
    check("R6 line kept", 32'(irq_o), 32'h4);
    check_all("R6 dest max");

    // R7: status writes ignored
    wr(AW'(2 * 8 + 4), 32'hFFFF_FFFF);
    rd(AW'(2 * 8 + 4), v);
    check("R7 status kept", v, 32'h0000_2222 | SEND);
    wr(AW'(0 * 8 + 4), 32'h0000_0000);
    check_all("R7 status write");

    // R9: overwrite of a pending message
    wr(AW'(1 * 8), SEND | (32'(2) << 16) | 32'h7777);
    rd(AW'(2 * 8 + 4), v);
    check("R9 overwrite", v, 32'h4001_7777);
    check_all("R9 overwrite");

    // R1: out-of-range slot
    wr(AW'(5 * 8), ACK | SEND | (32'(0) << 16) | 32'h9999);
    check("R1 far slot lines", 32'(irq_o), 32'h4);
    rd(AW'(5 * 8), v);
    check("R1 far read ctrl", v, 32'h0);
    rd(AW'(5 * 8 + 4), v);
    check("R1 far read status", v, 32'h0);
    check_all("R1 far slot");

    // R8: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    check_all("R8 reset again");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule